// File: doc/BRIEF.md
# Asynchronous Character Framer with Parity Options

The block turns one parallel byte into a single asynchronous serial character. The frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional fourth field, and finally one high stop bit. The fourth field can be a parity bit computed from the data, a parity bit held at a fixed level, an address/data marker taken from a separate input, or it can be left out. A byte is handed over with a valid/ready handshake. An external bit-rate enable pulse sets the pace, and each pulse advances the line by one bit. Between frames the line rests high.

A separate receive-side checker uses the same length and parity settings. It takes a received character and the bit found in the parity position, and it raises an error pulse when a parity bit was expected and does not match.

Top module: `async_char_framer`

## Requirements
- R1: After reset `line_out` is high, `busy` is low and `tx_ready` is high.
- R2: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low whenever `busy` is high. The line stays high until the next `tick`, and at that tick it drives the start bit (low).
- R3: The data bits follow the start bit, least significant first. `len_code` sets how many are sent: 00 sends 5, 01 sends 6, 10 sends 7 and 11 sends 8. Byte bits above the selected length are never sent and have no effect on parity.
- R4: With `par_mode` 00 (computed parity), one bit follows the data. It is the XOR of the sent data bits, XORed with `par_type`, where 0 gives even parity and 1 gives odd parity.
- R5: With `par_mode` 01 (forced parity), the bit after the data equals `par_type`, whatever the data.
- R6: With `par_mode` 10 (no parity), the stop bit follows the last data bit directly, and `par_type` has no effect.
- R7: With `par_mode` 11 (address marking), the bit after the data equals `addr_flag`.
- R8: The stop bit is high for one tick. On the following tick `busy` falls, and the line stays high while idle.
- R9: Data and all configuration inputs are captured when the byte is taken. Changing them while `busy` is high does not alter the frame in progress.
- R10: Every bit lasts from one `tick` to the next. `line_out` changes only on clock edges where `tick` is high.
- R11: One cycle after `rx_valid`, `rx_par_err` is high only if `par_mode` is 00 or 01 and `rx_par_bit` differs from the bit R4 or R5 would give for `rx_data`. In every other case it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-rate enable, one pulse per bit time |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Framer can take a byte |
| tx_data | input | 8 | Byte to send |
| len_code | input | 2 | Data length select (5 to 8 bits) |
| par_mode | input | 2 | Fourth-field mode select |
| par_type | input | 1 | Parity sense or forced level |
| addr_flag | input | 1 | Marker bit for address marking mode |
| line_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is pending or in progress |
| rx_valid | input | 1 | Received character present |
| rx_data | input | 8 | Received data bits |
| rx_par_bit | input | 1 | Bit received in the parity position |
| rx_par_err | output | 1 | Parity mismatch pulse |

## Verification
The assertions assume that `tick` and the handshake inputs are clean, synchronous, single-cycle levels, and that configuration only needs to be stable on the edge where a byte is taken. The stimulus drives every input on the falling clock edge. It sweeps all length and mode combinations at several tick spacings, including a tick on every cycle. Some frames deliberately change the configuration and data while `busy` is high. The receive inputs are randomised on every cycle, so the error pulse is exercised under each configuration the transmitter uses.

// File: rtl/afr_pkg.sv
package afr_pkg;
   typedef enum logic [1:0] {
      PM_CALC  = 2'b00,
      PM_FORCE = 2'b01,
      PM_NONE  = 2'b10,
      PM_MDROP = 2'b11
   } par_mode_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_ARM,
      FS_START,
      FS_DATA,
      FS_PAR,
      FS_STOP
   } fstate_e;
endpackage

// File: rtl/afr_width_mask.sv
module afr_width_mask #(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2
) (
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i < MIN_BITS) begin : g_always
         assign dout[i] = din[i];
      end else begin : g_cond
         assign dout[i] = din[i] & (int'(len) > (i - MIN_BITS));
      end
   end
endmodule

// File: rtl/afr_parity_gen.sv
module afr_parity_gen
   import afr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  par_mode_e         mode,
   input  logic              ptype,
   input  logic              aflag,
   input  logic [DATA_W-1:0] data_masked,
   output logic              has_bit,
   output logic              bit_val
);
   always_comb begin
      has_bit = 1'b1;
      bit_val = 1'b0;
      unique case (mode)
         PM_CALC:  bit_val = (^data_masked) ^ ptype;
         PM_FORCE: bit_val = ptype;
         PM_NONE:  has_bit = 1'b0;
         PM_MDROP: bit_val = aflag;
         default:  has_bit = 1'b0;
      endcase
   end
endmodule

// File: rtl/afr_tx_seq.sv
module afr_tx_seq
   import afr_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              acc_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CNT_W-1:0]  last_idx_i,
   input  logic              has_par_i,
   input  logic              par_i,
   output logic              line_o,
   output logic              busy_o
);
   fstate_e           st_q;
   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q, last_q;
   logic              hp_q, pv_q, line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         sh_q   <= '0;
         cnt_q  <= '0;
         last_q <= '0;
         hp_q   <= 1'b0;
         pv_q   <= 1'b0;
         line_q <= 1'b1;
      end else begin
         unique case (st_q)
            FS_IDLE: if (acc_i) begin
               st_q   <= FS_ARM;
               sh_q   <= data_i;
               last_q <= last_idx_i;
               hp_q   <= has_par_i;
               pv_q   <= par_i;
            end
            FS_ARM: if (tick) begin
               line_q <= 1'b0;
               st_q   <= FS_START;
            end
            FS_START: if (tick) begin
               line_q <= sh_q[0];
               sh_q   <= sh_q >> 1;
               cnt_q  <= '0;
               st_q   <= FS_DATA;
            end
            FS_DATA: if (tick) begin
               if (cnt_q == last_q) begin
                  line_q <= hp_q ? pv_q : 1'b1;
                  st_q   <= hp_q ? FS_PAR : FS_STOP;
               end else begin
                  line_q <= sh_q[0];
                  sh_q   <= sh_q >> 1;
                  cnt_q  <= cnt_q + 1'b1;
               end
            end
            FS_PAR: if (tick) begin
               line_q <= 1'b1;
               st_q   <= FS_STOP;
            end
            FS_STOP: if (tick) st_q <= FS_IDLE;
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign line_o = line_q;
   assign busy_o = (st_q != FS_IDLE);

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_IDLE) |-> line_q); // R8
   AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(line_q)); // R10
   AST_ACCEPT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i |=> (busy_o && line_q)); // R2
   AST_FRAME_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != FS_IDLE && $past(st_q) != FS_IDLE) |-> $stable({last_q, hp_q, pv_q})); // R9
endmodule

// File: rtl/afr_rx_check.sv
module afr_rx_check
   import afr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_bit,
   input  logic [LEN_W-1:0]  len,
   input  par_mode_e         mode,
   input  logic              ptype,
   output logic              err_o
);
   logic [DATA_W-1:0] masked;
   logic              has_bit, exp_bit, err_q;

   afr_width_mask #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) i_mask (
      .len(len), .din(rx_data), .dout(masked));

   afr_parity_gen #(.DATA_W(DATA_W)) i_pgen (
      .mode(mode), .ptype(ptype), .aflag(1'b0), .data_masked(masked),
      .has_bit(has_bit), .bit_val(exp_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= rx_valid && has_bit && (mode != PM_MDROP) && (rx_bit != exp_bit);
   end

   assign err_o = err_q;

   AST_RX_SILENT_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (mode == PM_NONE || mode == PM_MDROP)) |=> !err_q); // R11
   AST_RX_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !err_q); // R11
endmodule

// File: rtl/async_char_framer.sv
module async_char_framer
   import afr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2,
   localparam int CNT_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic [LEN_W-1:0]  len_code,
   input  logic [1:0]        par_mode,
   input  logic              par_type,
   input  logic              addr_flag,
   output logic              line_out,
   output logic              busy,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_bit,
   output logic              rx_par_err
);
   if (MIN_BITS < 1) begin : g_bad_min
      $error("MIN_BITS must be at least 1");
   end
   if (DATA_W < MIN_BITS + (2 ** LEN_W) - 1) begin : g_bad_width
      $error("DATA_W too small for the longest length code");
   end

   logic [DATA_W-1:0] tx_masked;
   logic [CNT_W-1:0]  last_idx;
   logic              has_par, par_val, accept;

   afr_width_mask #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) i_tx_mask (
      .len(len_code), .din(tx_data), .dout(tx_masked));

   afr_parity_gen #(.DATA_W(DATA_W)) i_tx_pgen (
      .mode(par_mode_e'(par_mode)), .ptype(par_type), .aflag(addr_flag),
      .data_masked(tx_masked), .has_bit(has_par), .bit_val(par_val));

   assign last_idx = CNT_W'(MIN_BITS - 1) + CNT_W'(len_code);
   assign tx_ready = !busy;
   assign accept   = tx_valid && tx_ready;

   afr_tx_seq #(.DATA_W(DATA_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .acc_i(accept), .data_i(tx_masked),
      .last_idx_i(last_idx), .has_par_i(has_par), .par_i(par_val),
      .line_o(line_out), .busy_o(busy));

   afr_rx_check #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) i_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_bit(rx_par_bit), .len(len_code), .mode(par_mode_e'(par_mode)),
      .ptype(par_type), .err_o(rx_par_err));
endmodule

// File: tb/test_async_char_framer.sv
module test_async_char_framer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, tx_valid = 1'b0;
   logic [7:0] tx_data = '0, rx_data = '0;
   logic [1:0] len_code = '0, par_mode = '0;
   logic       par_type = 1'b0, addr_flag = 1'b0, rx_valid = 1'b0, rx_par_bit = 1'b0;
   logic       tx_ready, line_out, busy, rx_par_err;

   async_char_framer i_async_char_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .len_code(len_code), .par_mode(par_mode), .par_type(par_type),
      .addr_flag(addr_flag), .line_out(line_out), .busy(busy), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_par_bit(rx_par_bit), .rx_par_err(rx_par_err));

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_checks = 0, n_errors = 0, tick_div = 1;
   bit    r9_mode = 0, run_rx = 0, chk_en = 0;
   bit    mq[$];
   string tq[$];
   bit    m_line = 1, m_busy = 0, m_rx_err = 0, m_tick = 1;
   string m_tag = "R1";

   function automatic bit xor_n(logic [7:0] d, int n);
      bit p = 0;
      for (int i = 0; i < n; i++) p ^= d[i];
      return p;
   endfunction

   task automatic check_bit(input logic act, input logic exp, input string tag, input string nm);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
      end
   endtask

   // Behavioural reference: a queue of the bits still to go out
   always @(posedge clk) begin
      bit pre_busy;
      int n;
      if (!rst_n) begin
         mq.delete(); tq.delete();
         m_line = 1; m_busy = 0; m_rx_err = 0; m_tag = "R1"; m_tick = 1;
      end else begin
         pre_busy = m_busy;
         m_tick   = tick;
         m_rx_err = 0;
         if (rx_valid) begin
            n = 5 + int'(len_code);
            if (par_mode == 2'b00) m_rx_err = (rx_par_bit != (xor_n(rx_data, n) ^ par_type));
            else if (par_mode == 2'b01) m_rx_err = (rx_par_bit != par_type);
         end
         if (tick) begin
            if (mq.size() > 0) begin
               m_line = mq.pop_front();
               m_tag  = tq.pop_front();
            end else if (m_busy) begin
               m_busy = 0; m_line = 1; m_tag = "R8";
            end
         end
         if (tx_valid && !pre_busy) begin
            n = 5 + int'(len_code);
            mq.push_back(1'b0); tq.push_back(r9_mode ? "R9" : "R2");
            for (int i = 0; i < n; i++) begin
               mq.push_back(tx_data[i]); tq.push_back(r9_mode ? "R9" : "R3");
            end
            case (par_mode)
               2'b00: begin mq.push_back(xor_n(tx_data, n) ^ par_type); tq.push_back(r9_mode ? "R9" : "R4"); end
               2'b01: begin mq.push_back(par_type); tq.push_back(r9_mode ? "R9" : "R5"); end
               2'b11: begin mq.push_back(addr_flag); tq.push_back(r9_mode ? "R9" : "R7"); end
               default: ;
            endcase
            mq.push_back(1'b1);
            tq.push_back(r9_mode ? "R9" : (par_mode == 2'b10 ? "R6" : "R8"));
            m_busy = 1;
            m_tag  = r9_mode ? "R9" : "R2";
         end
      end
   end

   always @(negedge clk) begin
      if (chk_en) begin
         check_bit(line_out, m_line, m_tick ? m_tag : "R10", "line_out");
         check_bit(busy, m_busy, m_tag, "busy");
         check_bit(tx_ready, !m_busy, m_tag == "R1" ? "R1" : "R2", "tx_ready");
         check_bit(rx_par_err, m_rx_err, "R11", "rx_par_err");
      end
   end

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         if (tc + 1 >= tick_div) begin tick = 1'b1; tc = 0; end
         else begin tick = 1'b0; tc++; end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         rx_valid   = run_rx && ($urandom % 2 == 1);
         rx_data    = 8'($urandom);
         rx_par_bit = 1'($urandom);
      end
   end

   task automatic send(input logic [7:0] d, input logic [1:0] l, input logic [1:0] m,
                       input logic t, input logic a, input bit chg);
      while (!tx_ready) @(negedge clk);
      tx_data = d; len_code = l; par_mode = m; par_type = t; addr_flag = a;
      r9_mode = chg; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      if (chg) begin
         repeat (3) @(negedge clk);
         tx_data = ~d; len_code = ~l; par_mode = ~m; par_type = ~t; addr_flag = ~a;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_en = 1;  // R1: reset state checked while rst_n is still low
      @(negedge clk);
      rst_n  = 1'b1;
      run_rx = 1;
      for (int dv = 1; dv <= 3; dv += 2) begin
         tick_div = dv;
         for (int m = 0; m < 4; m++)
            for (int l = 0; l < 4; l++)
               for (int t = 0; t < 2; t++)
                  send(8'($urandom), 2'(l), 2'(m), 1'(t), 1'($urandom), 0);
      end
      tick_div = 5;
      for (int k = 0; k < 8; k++)
         send(8'($urandom), 2'(k), 2'(k >> 1), 1'(k), 1'(k >> 2), 1);  // R9
      tick_div = 2;
      send(8'hE0, 2'b00, 2'b00, 1'b0, 1'b0, 0);  // R3: upper bits ignored
      send(8'h1F, 2'b10, 2'b10, 1'b1, 1'b1, 0);  // R6
      run_rx = 0;
      repeat (10) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule